// File: doc/BRIEF.md
# Pipelined Bus Slave with Wait-State Insertion

This block is the slave side of an AHB-style pipelined bus, placed in front of a small word-organised register file. Each transfer has two phases. In the address phase the slave samples the select, address, direction and size. In the following data phase it returns read data or stores write data. The data phase of one transfer overlaps the address phase of the next.

The slave takes two ready signals. `hready_in` is the bus-wide ready state, which the interconnect builds from whichever slave currently owns the data phase. `hready_out` is driven by this slave and stretches its own data phase. A select is accepted only while `hready_in` is high. A select that arrives while some other slave is holding the bus in a wait state is dropped. Every data phase this slave accepts runs for a fixed, parameterised number of wait states, followed by one completing cycle.

Top module: `ahb_wait_slave`

## Requirements
- R1: During and after synchronous reset, with no transfer accepted, `hready_out` is 1 and `hrdata` is 0.
- R2: An address phase is accepted only on a rising clock edge where `hsel`=1, `hready_in`=1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11).
- R3: A select presented while `hready_in`=0 is ignored. It writes nothing, and `hready_out` stays 1 on the following cycle.
- R4: Transfers of type IDLE (2'b00) or BUSY (2'b01) complete with no wait state and write nothing.
- R5: An accepted data phase holds `hready_out` at 0 for exactly WAIT_STATES cycles (0 to 3), then drives it to 1 for one completing cycle.
- R6: Write data on `hwdata` is committed at the end of the completing cycle. Only the byte lanes selected by `hsize` (0 = byte, 1 = halfword, 2 = word) at byte offset `haddr[1:0]` are written.
- R7: Read data is valid on `hrdata` only during the completing cycle of a read data phase. At all other times `hrdata` is 0.
- R8: `hresp` is always 0, meaning OKAY.
- R9: An address phase presented during a data phase is accepted on the edge that ends the completing cycle, so back-to-back transfers run pipelined.
- R10: The word written or read is the one selected by `haddr[ADDR_W-1:2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | ADDR_W | Byte address |
| hwrite | input | 1 | 1 = write, 0 = read |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hsize | input | 3 | Transfer size, as log2 of the number of bytes |
| hwdata | input | DATA_W | Write data, presented in the data phase |
| hready_in | input | 1 | Bus-wide ready: the previous data phase is complete |
| hready_out | output | 1 | This slave's ready; low stretches its data phase |
| hrdata | output | DATA_W | Read data |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
On every cycle, assertions check four things. They check that `hready_out` is high coming out of reset. They check that captured address state holds while `hready_in` is low. They check that the low stretch of `hready_out` before each completion lasts exactly WAIT_STATES cycles. They check that unqualified or IDLE/BUSY transfers leave the slave ready on the next cycle. Three other properties appear only in the bench's scenarios, because they need a memory model: that data lands in the right word and byte lanes, that read data appears only in the completing cycle, and that a pipelined read sees the write just before it.

// File: rtl/ahbws_pkg.sv
// Package: shared transfer-type encoding and captured-phase control record
// for the wait-state slave. Assumes the bus encodes IDLE/BUSY/NONSEQ/SEQ
// in two bits as below.
package ahbws_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    // Control fields held for the duration of one data phase
    typedef struct packed {
        logic       valid;
        logic       write;
        logic [2:0] size;
    } phase_ctl_t;

endpackage

// File: rtl/ahbws_addr_phase.sv
// Address-phase register: samples an address phase when the bus is ready
// and the transfer is qualified, and holds it through the data phase.
// Assumes hready_in is the bus-wide ready, so a captured phase cannot be
// replaced while its own data phase is being stretched.
module ahbws_addr_phase
    import ahbws_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int OFF_W  = 2,
    localparam int IDX_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic              hready_in,
    output phase_ctl_t        ph_ctl,
    output logic [IDX_W-1:0]  ph_idx,
    output logic [OFF_W-1:0]  ph_off
);

    logic qualified;

    // Purpose: a transfer is accepted only when selected, bus-ready and active
    always_comb begin
        qualified = hsel && hready_in &&
                    ((htrans == TR_NONSEQ) || (htrans == TR_SEQ));
    end

    // Purpose: capture the address phase on a ready edge, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_ctl <= '0;
            ph_idx <= '0;
            ph_off <= '0;
        end else if (hready_in) begin
            ph_ctl.valid <= qualified;
            if (qualified) begin
                ph_ctl.write <= hwrite;
                ph_ctl.size  <= hsize;
                ph_idx       <= haddr[ADDR_W-1:OFF_W];
                ph_off       <= haddr[OFF_W-1:0];
            end
        end
    end

    // R3: while the bus is stalled nothing captured may change
    a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_in |=> ($stable(ph_idx) && $stable(ph_ctl) && $stable(ph_off)));

    // R2: an unqualified ready edge leaves no data phase behind
    a_r2_capture_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_in && !(hsel && htrans[1])) |=> !ph_ctl.valid);

endmodule

// File: rtl/ahbws_wait_ctrl.sv
// Wait-state controller: for an active data phase, holds ready low for
// WAIT_STATES cycles and then high for one completing cycle. Ready is high
// whenever no data phase of this slave is active. Assumes "active" only
// changes on edges where this slave's ready is high.
module ahbws_wait_ctrl #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic hready_out
);

    generate
        if (WAIT_STATES == 0) begin : g_no_wait
            // Purpose: zero wait states, every data phase completes at once
            always_comb begin
                hready_out = 1'b1;
            end
        end else begin : g_wait
            localparam int CNT_W = $clog2(WAIT_STATES + 1);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_STATES);

            logic [CNT_W-1:0] cnt;
            logic [CNT_W-1:0] low_run;

            // Purpose: ready rises once the wait count reaches its limit
            always_comb begin
                hready_out = !active || (cnt == LAST);
            end

            // Purpose: count wait cycles within the active phase, clear on completion
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (active && (cnt != LAST)) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                end
            end

            // Purpose: independent length of the current low stretch of ready
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_run <= '0;
                end else if (!hready_out) begin
                    low_run <= low_run + 1'b1;
                end else begin
                    low_run <= '0;
                end
            end

            // R5: each completing cycle follows exactly WAIT_STATES low cycles
            a_r5_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
                (active && hready_out) |-> (low_run == LAST));

            // R5: a stretched phase is never abandoned before it completes
            a_r5_no_abandon: assert property (@(posedge clk) disable iff (!rst_n)
                (active && !hready_out) |=> active);
        end
    endgenerate

endmodule

// File: rtl/ahbws_regfile.sv
// Register file behind the slave: byte-lane writes selected by transfer
// size and byte offset, and a read port that drives zero unless a read
// completes. Assumes size/offset describe a naturally aligned transfer.
module ahbws_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [BYTES-1:0]  lane_en;

    // Purpose: a byte lane is enabled when it shares the aligned block of the offset
    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            if (int'(size) >= OFF_W) begin
                lane_en[i] = 1'b1;
            end else begin
                lane_en[i] = ((i >> size) == (int'(off) >> size));
            end
        end
    end

    // Purpose: clear storage on reset, merge enabled lanes on a completing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem[w] <= '0;
            end
        end else if (we) begin
            for (int i = 0; i < BYTES; i++) begin
                if (lane_en[i]) begin
                    mem[idx][8*i +: 8] <= wdata[8*i +: 8];
                end
            end
        end
    end

    // Purpose: present the addressed word only in a completing read cycle
    always_comb begin
        rdata = re ? mem[idx] : '0;
    end

endmodule

// File: rtl/ahb_wait_slave.sv
// Top of the wait-state slave: address-phase capture gated by the shared
// ready input, wait-state insertion on its own ready output, and a byte-lane
// register file. Responses are always OKAY. Assumes the interconnect feeds
// this slave's hready_out back into hready_in while it owns the data phase.
module ahb_wait_slave
    import ahbws_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hwrite,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready_in,
    output logic              hready_out,
    output logic [DATA_W-1:0] hrdata,
    output logic              hresp
);

    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W = ADDR_W - OFF_W;

    phase_ctl_t       ph_ctl;
    logic [IDX_W-1:0] ph_idx;
    logic [OFF_W-1:0] ph_off;
    logic             wr_commit;
    logic             rd_present;

    ahbws_addr_phase #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsel      (hsel),
        .haddr     (haddr),
        .hwrite    (hwrite),
        .htrans    (htrans),
        .hsize     (hsize),
        .hready_in (hready_in),
        .ph_ctl    (ph_ctl),
        .ph_idx    (ph_idx),
        .ph_off    (ph_off)
    );

    ahbws_wait_ctrl #(
        .WAIT_STATES (WAIT_STATES)
    ) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (ph_ctl.valid),
        .hready_out (hready_out)
    );

    // Purpose: commit writes and expose reads only in the completing cycle
    always_comb begin
        wr_commit  = ph_ctl.valid &&  ph_ctl.write && hready_out;
        rd_present = ph_ctl.valid && !ph_ctl.write && hready_out;
    end

    ahbws_regfile #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_commit),
        .re    (rd_present),
        .idx   (ph_idx),
        .off   (ph_off),
        .size  (ph_ctl.size),
        .wdata (hwdata),
        .rdata (hrdata)
    );

    // Purpose: this slave never signals an error response
    always_comb begin
        hresp = 1'b0;
    end

    // R1: first cycle after reset release the slave is ready
    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> hready_out);

    // R4: an IDLE or BUSY transfer on a ready edge leaves the bus ready
    a_r4_idle_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_in && hsel && !htrans[1]) |=> hready_out);

endmodule

// File: tb/ahb_wait_slave_test.sv
// Self-checking bench: directed corner cases plus seeded random transfers,
// compared against a shadow memory maintained by bench functions.
module ahb_wait_slave_test;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam int WS = 2;
    localparam int NW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic          hwrite = 1'b0;
    logic [1:0]    htrans = 2'b00;
    logic [2:0]    hsize = 3'd2;
    logic [DW-1:0] hwdata = '0;
    logic          hready_in;
    logic          hready_out;
    logic [DW-1:0] hrdata;
    logic          hresp;
    logic          foreign_busy = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] shadow [NW];

    always #2.5 clk = ~clk;

    // Bus-wide ready: this slave's ready unless another slave is stretching
    assign hready_in = hready_out && !foreign_busy;

    ahb_wait_slave #(.DATA_W(DW), .ADDR_W(AW), .WAIT_STATES(WS)) uut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .hwrite(hwrite),
        .htrans(htrans), .hsize(hsize), .hwdata(hwdata), .hready_in(hready_in),
        .hready_out(hready_out), .hrdata(hrdata), .hresp(hresp)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input int sz, input int off);
        logic [DW-1:0] r = old;
        int nb = 1 << sz;
        int base = (off / nb) * nb;
        for (int i = 0; i < DW/8; i++)
            if (sz >= 2 || (i >= base && i < base + nb)) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction

    // One isolated transfer: address phase, then data phase until ready
    task automatic xfer(input bit wr, input int idx, input int sz, input int off,
                        input logic [DW-1:0] wd, input logic [1:0] tr,
                        output logic [DW-1:0] rd, output int waits);
        @(negedge clk);
        hsel = 1'b1; htrans = tr; hwrite = wr; hsize = 3'(sz);
        haddr = AW'(idx * 4 + off);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = wd;
        #1;
        waits = 0;
        while (!hready_out && waits < 10) begin
            check("R7 hrdata quiet while waiting", hrdata, '0);
            waits++;
            @(negedge clk); #1;
        end
        rd = hrdata;
        check("R8 hresp okay", {31'd0, hresp}, '0);
    endtask

    task automatic do_write(input int idx, input int sz, input int off, input logic [DW-1:0] wd,
                            input logic [1:0] tr);
        logic [DW-1:0] rd; int w;
        xfer(1'b1, idx, sz, off, wd, tr, rd, w);
        check("R5 write wait count", DW'(w), DW'(WS));
        shadow[idx] = merge(shadow[idx], wd, sz, off);
    endtask

    task automatic do_read(input int idx, input string req, input logic [1:0] tr);
        logic [DW-1:0] rd; int w;
        xfer(1'b0, idx, 2, 0, '0, tr, rd, w);
        check("R5 read wait count", DW'(w), DW'(WS));
        check(req, rd, shadow[idx]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int w;
        int seed_dummy;
        for (int i = 0; i < NW; i++) shadow[i] = '0;
        seed_dummy = $urandom(1234);
        repeat (3) @(negedge clk);
        check("R1 ready during reset", {31'd0, hready_out}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 ready after reset", {31'd0, hready_out}, 32'd1);
        check("R1 hrdata zero after reset", hrdata, '0);

        // R6 R10: word, byte and half writes to one word, then others
        do_write(3, 2, 0, 32'hA1B2C3D4, 2'b10);
        do_read(3, "R10 word read back", 2'b10);
        do_write(3, 0, 1, 32'h0000EE00, 2'b10);
        do_read(3, "R6 byte lane merge", 2'b10);
        do_write(3, 1, 2, 32'h55660000, 2'b11);
        do_read(3, "R6 halfword lane merge", 2'b11);
        do_write(12, 2, 0, 32'hCAFEF00D, 2'b10);
        do_read(12, "R10 other word", 2'b10);
        do_read(3, "R10 first word intact", 2'b10);

        // R4: IDLE and BUSY selected transfers complete at once and write nothing
        xfer(1'b1, 5, 2, 0, 32'hDEADBEEF, 2'b00, rd, w);
        check("R4 idle zero wait", DW'(w), 32'd0);
        xfer(1'b1, 5, 2, 0, 32'hDEADBEEF, 2'b01, rd, w);
        check("R4 busy zero wait", DW'(w), 32'd0);
        do_read(5, "R4 idle/busy wrote nothing", 2'b10);

        // R3: select while another slave stretches the bus
        @(negedge clk);
        foreign_busy = 1'b1;
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2; haddr = AW'(6 * 4);
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = 32'h12345678;
        #1;
        check("R3 ready stays high", {31'd0, hready_out}, 32'd1);
        @(negedge clk);
        foreign_busy = 1'b0;
        #1;
        check("R3 no late response", {31'd0, hready_out}, 32'd1);
        check("R2 no read data without capture", hrdata, '0);
        do_read(6, "R3 ignored select wrote nothing", 2'b10);

        // R9: write then pipelined read of the same word
        @(negedge clk);
        hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; hsize = 3'd2; haddr = AW'(7 * 4);
        @(negedge clk);
        hwdata = 32'h0BADC0DE;
        hwrite = 1'b0; htrans = 2'b11;
        #1;
        w = 0;
        while (!hready_out && w < 10) begin w++; @(negedge clk); #1; end
        check("R9 first phase waits", DW'(w), DW'(WS));
        shadow[7] = 32'h0BADC0DE;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        #1;
        check("R9 second phase accepted (stretching)", {31'd0, hready_out}, (WS == 0) ? 32'd1 : 32'd0);
        w = 0;
        while (!hready_out && w < 10) begin w++; @(negedge clk); #1; end
        check("R9 second phase waits", DW'(w), DW'(WS));
        check("R9 pipelined read sees write", hrdata, 32'h0BADC0DE);

        // Random mix of sizes, offsets, types and directions
        for (int n = 0; n < 300; n++) begin
            int idx = int'($urandom % NW);
            int sz  = int'($urandom % 3);
            int off = (int'($urandom % 4) >> sz) << sz;
            logic [1:0] tr = ($urandom % 2) ? 2'b11 : 2'b10;
            if ($urandom % 2) do_write(idx, sz, off, $urandom, tr);
            else do_read(idx, "R7 random read data", tr);
        end

        @(negedge clk); #1;
        check("R1 ready when idle", {31'd0, hready_out}, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule